// File: doc/BRIEF.md
# Segment-or-Page Address Translator

This block is the front end of a memory management unit. It takes one access request at a time (virtual address, access kind, privilege) and decides how it is translated. With translation switched off, the address is passed through untouched and every permission is granted. A kernel access that falls in a segment flagged for direct mapping is relocated by swapping in a 4-bit physical high nibble, again with every permission granted. Every other access is sent out on a lookup port to an external page TLB, and the TLB's answer is handed back unchanged on the response channel.

The block holds the translation-enable bits, a 16-bit direct-segment mask and two packed registers of kernel segment base nibbles. All of them are loaded through a simple register-write port. Requests and responses use valid/ready handshakes. Only one access is in flight at a time, and its route is fixed when the request is accepted.

Top module: `segpage_xlator`

## Requirements
- R1: After reset, reqReady is 1, rspValid and tlbReqValid are 0, and every configuration register is 0, so translation is off.
- R2: Translation is on when bit 2 or bit 3 of the global configuration word is set. When it is off, rspPaddr equals the request address, rspPerm is 3'b111 ({exec,write,read}), rspFault is 0, and no lookup is issued.
- R3: The segment number is address bits [31:28]. An access is mapped directly when translation is on, reqUser is 0 and the mask bit indexed by the segment number is set.
- R4: On a direct mapping the base nibble comes from the low base register for segments 0 to 7 and from the high one for segments 8 to 15, at bit offset 4*(segment mod 8). rspPaddr is {nibble, vaddr[27:0]}, rspPerm is 3'b111 and rspFault is 0.
- R5: Every other access with translation on raises tlbReqValid carrying the request address, kind and user flag. tlbReqInstr is 1 exactly when the kind is execute (reqKind 2'd2). Kinds 0 (read), 1 (write) and 3 go to the data side.
- R6: For a looked-up access, the TLB's paddr, permissions, fault flag and fault code appear unchanged on the response.
- R7: A direct or pass-through response is valid in the first cycle after acceptance. A looked-up access raises tlbReqValid in the first cycle after acceptance, and the response is valid in the cycle after the TLB response is taken.
- R8: Only one access is outstanding: reqReady is 0 from acceptance until the response is taken. rspValid and the response fields, and tlbReqValid with its fields, stay stable until their ready is seen.
- R9: Configuration writes use cfgWrSel 0 for the global word, 1 for the mask (data bits [15:0]), 2 for the low base register and 3 for the high one. A write applies to requests accepted after it and never alters the route or result of an access already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrSel | input | 2 | Configuration register select |
| cfgWrData | input | 32 | Configuration write data |
| reqValid | input | 1 | Access request valid |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | 32 | Virtual address |
| reqKind | input | 2 | 0 read, 1 write, 2 execute, 3 treated as data |
| reqUser | input | 1 | Access is from user mode |
| rspValid | output | 1 | Translation result valid |
| rspReady | input | 1 | Requester takes the result |
| rspPaddr | output | 32 | Physical address |
| rspPerm | output | 3 | Granted permissions {exec,write,read} |
| rspFault | output | 1 | Translation fault |
| rspCode | output | 4 | Fault code from the TLB |
| tlbReqValid | output | 1 | Lookup request valid |
| tlbReqReady | input | 1 | TLB takes the lookup |
| tlbReqVaddr | output | 32 | Lookup address |
| tlbReqKind | output | 2 | Lookup access kind |
| tlbReqUser | output | 1 | Lookup privilege |
| tlbReqInstr | output | 1 | 1 for instruction-side lookup |
| tlbRspValid | input | 1 | TLB result valid |
| tlbRspReady | output | 1 | Block takes the TLB result |
| tlbRspPaddr | input | 32 | TLB physical address |
| tlbRspPerm | input | 3 | TLB permissions |
| tlbRspFault | input | 1 | TLB fault flag |
| tlbRspCode | input | 4 | TLB fault code |

## Verification
Directed accesses separate the enable bits, each alone and both clear. They separate kernel from user on a flagged segment. They probe segments at both ends of each base register, which catches a wrong register choice or nibble offset, and use an execute access to tell the instruction side from the data side. Random addresses, kinds and privileges mixed with random reconfiguration cover the route choice over the whole segment space, against a TLB model whose accept and response delays vary. Two in-flight cases rewrite the base register while a direct result is held, and switch translation off while a lookup is pending, so that a route taken from live registers instead of captured state shows up.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_t;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_TREQ  = 2'd1,
    XS_TWAIT = 2'd2,
    XS_RESP  = 2'd3
  } xlState_t;

  typedef struct packed {
    logic capReq;
    logic capDirect;
    logic capTlb;
  } xlStrobe_t;

  localparam logic [1:0] CFG_SEL_GLOBAL = 2'd0;
  localparam logic [1:0] CFG_SEL_MASK   = 2'd1;
  localparam logic [1:0] CFG_SEL_BASELO = 2'd2;
  localparam logic [1:0] CFG_SEL_BASEHI = 2'd3;

  localparam int ENABLE_BIT_A = 2;
  localparam int ENABLE_BIT_B = 3;
  localparam int PERM_W       = 3;
endpackage

// File: rtl/segxl_route.sv
module segxl_route #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  localparam int NUM_SEG = 1 << SEG_W,
  localparam int BASE_W  = (NUM_SEG / 2) * SEG_W
) (
  input  logic [ADDR_W-1:0]  vaddr,
  input  logic               user,
  input  logic [1:0]         enBits,
  input  logic [NUM_SEG-1:0] segMask,
  input  logic [BASE_W-1:0]  baseLo,
  input  logic [BASE_W-1:0]  baseHi,
  output logic               usePage,
  output logic               mmuOn,
  output logic [ADDR_W-1:0]  directPaddr
);
  logic [SEG_W-1:0]  segNum;
  logic [SEG_W-2:0]  lowIdx;
  logic [BASE_W-1:0] baseSel;
  logic [SEG_W-1:0]  nibble;
  logic              segDirect;

  always_comb begin
    segNum    = vaddr[ADDR_W-1 -: SEG_W];
    lowIdx    = segNum[SEG_W-2:0];
    mmuOn     = |enBits;
    segDirect = !user && segMask[segNum];
    baseSel   = segNum[SEG_W-1] ? baseHi : baseLo;
    nibble    = baseSel[lowIdx*SEG_W +: SEG_W];
    usePage   = mmuOn && !segDirect;
    if (!mmuOn) directPaddr = vaddr;
    else        directPaddr = {nibble, vaddr[ADDR_W-SEG_W-1:0]};
  end
endmodule

// File: rtl/segxl_datapath.sv
module segxl_datapath
  import segxl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int CODE_W = 4,
  localparam int NUM_SEG = 1 << SEG_W,
  localparam int BASE_W  = (NUM_SEG / 2) * SEG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgWrSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [1:0]        reqKind,
  input  logic              reqUser,
  input  xlStrobe_t         strobe,
  output logic              routePage,
  output logic [ADDR_W-1:0] tlbReqVaddr,
  output logic [1:0]        tlbReqKind,
  output logic              tlbReqUser,
  output logic              tlbReqInstr,
  input  logic [ADDR_W-1:0] tlbRspPaddr,
  input  logic [PERM_W-1:0] tlbRspPerm,
  input  logic              tlbRspFault,
  input  logic [CODE_W-1:0] tlbRspCode,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [PERM_W-1:0] rspPerm,
  output logic              rspFault,
  output logic [CODE_W-1:0] rspCode
);
  logic [1:0]         enBits;
  logic [NUM_SEG-1:0] segMask;
  logic [BASE_W-1:0]  baseLo;
  logic [BASE_W-1:0]  baseHi;
  logic [ADDR_W-1:0]  directPaddr;
  logic               mmuOn;
  logic [ADDR_W-1:0]  vaddrQ;
  logic [1:0]         kindQ;
  logic               userQ;

  segxl_route #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) route_i (
    .vaddr(reqVaddr), .user(reqUser), .enBits(enBits), .segMask(segMask),
    .baseLo(baseLo), .baseHi(baseHi), .usePage(routePage), .mmuOn(mmuOn),
    .directPaddr(directPaddr)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBits  <= '0;
      segMask <= '0;
      baseLo  <= '0;
      baseHi  <= '0;
    end else if (cfgWrEn) begin
      unique case (cfgWrSel)
        CFG_SEL_GLOBAL: enBits  <= {cfgWrData[ENABLE_BIT_B], cfgWrData[ENABLE_BIT_A]};
        CFG_SEL_MASK:   segMask <= cfgWrData[NUM_SEG-1:0];
        CFG_SEL_BASELO: baseLo  <= cfgWrData[BASE_W-1:0];
        CFG_SEL_BASEHI: baseHi  <= cfgWrData[BASE_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ <= '0;
      kindQ  <= '0;
      userQ  <= 1'b0;
    end else if (strobe.capReq) begin
      vaddrQ <= reqVaddr;
      kindQ  <= reqKind;
      userQ  <= reqUser;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPaddr <= '0;
      rspPerm  <= '0;
      rspFault <= 1'b0;
      rspCode  <= '0;
    end else if (strobe.capDirect) begin
      rspPaddr <= directPaddr;
      rspPerm  <= '1;
      rspFault <= 1'b0;
      rspCode  <= '0;
    end else if (strobe.capTlb) begin
      rspPaddr <= tlbRspPaddr;
      rspPerm  <= tlbRspPerm;
      rspFault <= tlbRspFault;
      rspCode  <= tlbRspCode;
    end
  end

  assign tlbReqVaddr = vaddrQ;
  assign tlbReqKind  = kindQ;
  assign tlbReqUser  = userQ;
  assign tlbReqInstr = (kindQ == ACC_EXEC);

  // R2: pass-through result equals the accepted address
  p_bypass_identity_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capDirect && !mmuOn) |=> (rspPaddr == $past(reqVaddr)));
  // R4: direct mapping keeps the in-segment offset and grants everything
  p_seg_offset_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capDirect |=> (rspPaddr[ADDR_W-SEG_W-1:0] == $past(reqVaddr[ADDR_W-SEG_W-1:0])
                          && (&rspPerm) && !rspFault));
  // R6: lookup result is forwarded untouched
  p_tlb_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capTlb |=> (rspPaddr == $past(tlbRspPaddr) && rspPerm == $past(tlbRspPerm)
                       && rspFault == $past(tlbRspFault) && rspCode == $past(tlbRspCode)));
  // R8: captured request stays put until a new one is taken
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capReq |=> ($stable(tlbReqVaddr) && $stable(tlbReqKind) && $stable(tlbReqUser)));
endmodule

// File: rtl/segxl_control.sv
module segxl_control
  import segxl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      routePage,
  input  logic      rspReady,
  input  logic      tlbReqReady,
  input  logic      tlbRspValid,
  output logic      reqReady,
  output logic      rspValid,
  output logic      tlbReqValid,
  output logic      tlbRspReady,
  output xlStrobe_t strobe
);
  xlState_t state, stateNext;

  always_comb begin
    reqReady    = (state == XS_IDLE);
    tlbReqValid = (state == XS_TREQ);
    tlbRspReady = (state == XS_TWAIT);
    rspValid    = (state == XS_RESP);
    strobe.capReq    = reqReady && reqValid;
    strobe.capDirect = strobe.capReq && !routePage;
    strobe.capTlb    = tlbRspReady && tlbRspValid;
    stateNext = state;
    unique case (state)
      XS_IDLE:  if (strobe.capReq) stateNext = routePage ? XS_TREQ : XS_RESP;
      XS_TREQ:  if (tlbReqReady) stateNext = XS_TWAIT;
      XS_TWAIT: if (tlbRspValid) stateNext = XS_RESP;
      XS_RESP:  if (rspReady) stateNext = XS_IDLE;
      default:  stateNext = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= XS_IDLE;
    else       state <= stateNext;
  end

  // R8: response held until taken
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);
  // R8: lookup request held until taken
  p_tlb_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tlbReqValid && !tlbReqReady) |=> tlbReqValid);
  // R8: at most one access outstanding
  p_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!rspValid && !tlbReqValid && !tlbRspReady));
  // R7: direct results respond in the next cycle
  p_direct_lat_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capDirect |=> rspValid);
  // R7: lookups start in the next cycle
  p_page_lat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capReq && routePage) |=> tlbReqValid);
  // R7: response follows the taken TLB result
  p_tlb_to_rsp_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capTlb |=> rspValid);
endmodule

// File: rtl/segpage_xlator.sv
module segpage_xlator
  import segxl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgWrSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [1:0]        reqKind,
  input  logic              reqUser,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [2:0]        rspPerm,
  output logic              rspFault,
  output logic [CODE_W-1:0] rspCode,
  output logic              tlbReqValid,
  input  logic              tlbReqReady,
  output logic [ADDR_W-1:0] tlbReqVaddr,
  output logic [1:0]        tlbReqKind,
  output logic              tlbReqUser,
  output logic              tlbReqInstr,
  input  logic              tlbRspValid,
  output logic              tlbRspReady,
  input  logic [ADDR_W-1:0] tlbRspPaddr,
  input  logic [2:0]        tlbRspPerm,
  input  logic              tlbRspFault,
  input  logic [CODE_W-1:0] tlbRspCode
);
  xlStrobe_t strobe;
  logic      routePage;

  segxl_control ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .routePage(routePage),
    .rspReady(rspReady), .tlbReqReady(tlbReqReady), .tlbRspValid(tlbRspValid),
    .reqReady(reqReady), .rspValid(rspValid), .tlbReqValid(tlbReqValid),
    .tlbRspReady(tlbRspReady), .strobe(strobe)
  );

  segxl_datapath #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .CODE_W(CODE_W)) dp_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .reqVaddr(reqVaddr), .reqKind(reqKind),
    .reqUser(reqUser), .strobe(strobe), .routePage(routePage),
    .tlbReqVaddr(tlbReqVaddr), .tlbReqKind(tlbReqKind), .tlbReqUser(tlbReqUser),
    .tlbReqInstr(tlbReqInstr), .tlbRspPaddr(tlbRspPaddr), .tlbRspPerm(tlbRspPerm),
    .tlbRspFault(tlbRspFault), .tlbRspCode(tlbRspCode), .rspPaddr(rspPaddr),
    .rspPerm(rspPerm), .rspFault(rspFault), .rspCode(rspCode)
  );

  // R8: response fields stable while waiting for the requester
  p_rsp_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> ($stable(rspPaddr) && $stable(rspPerm)
                                 && $stable(rspFault) && $stable(rspCode)));
  // R5: a lookup is never raised while a result is pending
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(tlbReqValid && rspValid));
endmodule

// File: tb/segpage_xlator_tb_top.sv
module segpage_xlator_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgWrSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [31:0] rspPaddr;
  logic [2:0]  rspPerm;
  logic        rspFault;
  logic [3:0]  rspCode;
  logic        tlbReqValid;
  logic        tlbReqReady = 1'b0;
  logic [31:0] tlbReqVaddr;
  logic [1:0]  tlbReqKind;
  logic        tlbReqUser;
  logic        tlbReqInstr;
  logic        tlbRspValid = 1'b0;
  logic        tlbRspReady;
  logic [31:0] tlbRspPaddr = '0;
  logic [2:0]  tlbRspPerm = '0;
  logic        tlbRspFault = 1'b0;
  logic [3:0]  tlbRspCode = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  logic [31:0] shCfg = '0, shMask = '0, shLo = '0, shHi = '0;
  logic [31:0] expVa = '0;
  logic [1:0]  expKind = '0;
  bit          expUser = 0;
  bit          tlbSeen = 0;
  int          tlbLat = 1;
  int          tlbAccDelay = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segpage_xlator dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqKind(reqKind),
    .reqUser(reqUser), .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr),
    .rspPerm(rspPerm), .rspFault(rspFault), .rspCode(rspCode), .tlbReqValid(tlbReqValid),
    .tlbReqReady(tlbReqReady), .tlbReqVaddr(tlbReqVaddr), .tlbReqKind(tlbReqKind),
    .tlbReqUser(tlbReqUser), .tlbReqInstr(tlbReqInstr), .tlbRspValid(tlbRspValid),
    .tlbRspReady(tlbRspReady), .tlbRspPaddr(tlbRspPaddr), .tlbRspPerm(tlbRspPerm),
    .tlbRspFault(tlbRspFault), .tlbRspCode(tlbRspCode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // TLB model contents
  function automatic logic [31:0] mPaddr(input logic [31:0] va);
    return va ^ 32'hA5A5_0000;
  endfunction
  function automatic logic [2:0] mPerm(input logic [31:0] va);
    return va[6:4];
  endfunction
  function automatic logic mFault(input logic [31:0] va);
    return va[7];
  endfunction
  function automatic logic [3:0] mCode(input logic [31:0] va);
    return va[3:0];
  endfunction

  // Expected route from the requirements
  function automatic void expRoute(input logic [31:0] va, input bit us,
                                   output bit paged, output logic [31:0] pa);
    int seg;
    logic [31:0] base;
    logic [3:0] nib;
    seg = int'(va[31:28]);
    paged = 0;
    pa = va;
    if (shCfg[2] || shCfg[3]) begin
      if (!us && shMask[seg]) begin
        base = (seg < 8) ? shLo : shHi;
        nib = 4'((base >> (4 * (seg % 8))) & 32'hF);
        pa = {nib, va[27:0]};
      end else begin
        paged = 1;
      end
    end
  endfunction

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
    case (sel)
      2'd0: shCfg = data;
      2'd1: shMask = {16'h0, data[15:0]};
      2'd2: shLo = data;
      default: shHi = data;
    endcase
  endtask

  task automatic issue(input logic [31:0] va, input logic [1:0] kd, input bit us);
    @(negedge clk);
    expVa = va; expKind = kd; expUser = us; tlbSeen = 0;
    reqValid = 1'b1; reqVaddr = va; reqKind = kd; reqUser = us;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitRsp(output int lat);
    lat = 1;
    while (!rspValid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic release_rsp();
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
  endtask

  task automatic access(input logic [31:0] va, input logic [1:0] kd, input bit us,
                        input string tag);
    bit paged;
    logic [31:0] pa;
    int lat;
    expRoute(va, us, paged, pa);
    chk(reqReady === 1'b1, "R8", {tag, " ready before issue"}, 32'(reqReady), 32'd1);
    issue(va, kd, us);
    chk(reqReady === 1'b0, "R8", {tag, " busy after accept"}, 32'(reqReady), 32'd0);
    waitRsp(lat);
    if (!paged) begin
      chk(lat == 1, "R7", {tag, " direct latency"}, 32'(lat), 32'd1);
      chk(rspPaddr === pa, (shCfg[3:2] == 0) ? "R2" : "R4", {tag, " paddr"}, rspPaddr, pa);
      chk(rspPerm === 3'b111 && rspFault === 1'b0, "R4", {tag, " perm/fault"},
          {28'h0, rspFault, rspPerm}, 32'h7);
      chk(tlbSeen == 0, "R3", {tag, " no lookup"}, 32'(tlbSeen), 32'd0);
    end else begin
      chk(tlbSeen == 1, "R5", {tag, " lookup issued"}, 32'(tlbSeen), 32'd1);
      chk(rspPaddr === mPaddr(va), "R6", {tag, " paddr"}, rspPaddr, mPaddr(va));
      chk({rspPerm, rspFault, rspCode} === {mPerm(va), mFault(va), mCode(va)}, "R6",
          {tag, " perm/fault/code"}, {24'h0, rspPerm, rspFault, rspCode},
          {24'h0, mPerm(va), mFault(va), mCode(va)});
    end
    release_rsp();
  endtask

  // TLB model
  initial begin
    forever begin
      @(negedge clk);
      if (tlbReqValid === 1'b1) begin
        tlbSeen = 1;
        chk(tlbReqVaddr === expVa, "R5", "lookup vaddr", tlbReqVaddr, expVa);
        chk(tlbReqInstr === (expKind == 2'd2), "R5", "instruction side flag",
            32'(tlbReqInstr), 32'(expKind == 2'd2));
        chk({tlbReqKind, tlbReqUser} === {expKind, expUser}, "R5", "kind/user",
            {29'h0, tlbReqKind, tlbReqUser}, {29'h0, expKind, expUser});
        repeat (tlbAccDelay) @(negedge clk);
        tlbReqReady = 1'b1;
        @(negedge clk);
        tlbReqReady = 1'b0;
        repeat (tlbLat) @(negedge clk);
        tlbRspPaddr = mPaddr(expVa);
        tlbRspPerm  = mPerm(expVa);
        tlbRspFault = mFault(expVa);
        tlbRspCode  = mCode(expVa);
        tlbRspValid = 1'b1;
        @(negedge clk);
        tlbRspValid = 1'b0;
      end
    end
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    bit paged;
    logic [31:0] pa;
    int lat;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady === 1'b1, "R1", "reqReady after reset", 32'(reqReady), 32'd1);
    chk(rspValid === 1'b0 && tlbReqValid === 1'b0, "R1", "valids after reset",
        {30'h0, rspValid, tlbReqValid}, 32'h0);
    access(32'h7123_4567, 2'd1, 1'b1, "R1 off after reset");

    // R2 enable bits individually
    cfgWrite(2'd1, 32'h0000_FFFF);
    cfgWrite(2'd0, 32'hFFFF_FFF3);
    access(32'h3ABC_DEF0, 2'd2, 1'b0, "R2 other bits only");
    cfgWrite(2'd0, 32'h0000_0004);
    access(32'h3ABC_DEF0, 2'd0, 1'b1, "R2 bit2 user");
    cfgWrite(2'd0, 32'h0000_0008);
    access(32'h3ABC_DEF0, 2'd0, 1'b1, "R2 bit3 user");

    // R3/R4 segment selection at register edges
    cfgWrite(2'd2, 32'h89AB_CDEF);
    cfgWrite(2'd3, 32'h0123_4567);
    cfgWrite(2'd1, 32'h0000_8181);
    access(32'h0111_2222, 2'd0, 1'b0, "R4 seg0");
    access(32'h7111_2222, 2'd1, 1'b0, "R4 seg7");
    access(32'h8111_2222, 2'd0, 1'b0, "R4 seg8");
    access(32'hF111_2222, 2'd2, 1'b0, "R4 seg15");
    access(32'hF111_2222, 2'd0, 1'b1, "R3 user on flagged seg");
    access(32'h1111_2222, 2'd0, 1'b0, "R3 kernel unflagged seg");
    access(32'h2000_00F5, 2'd2, 1'b0, "R5 exec lookup");
    access(32'h2000_0085, 2'd3, 1'b0, "R5 reserved kind data side");

    // R9 in-flight direct result not altered by base rewrite
    expRoute(32'h7000_1234, 1'b0, paged, pa);
    issue(32'h7000_1234, 2'd0, 1'b0);
    cfgWrite(2'd2, 32'h1234_5678);
    waitRsp(lat);
    chk(rspPaddr === pa, "R9", "held direct result after base write", rspPaddr, pa);
    release_rsp();
    access(32'h7000_1234, 2'd0, 1'b0, "R9 new base applies");

    // R9 in-flight lookup not altered by disabling translation
    tlbLat = 6;
    issue(32'h5000_0042, 2'd1, 1'b0);
    cfgWrite(2'd0, 32'h0);
    waitRsp(lat);
    chk(tlbSeen == 1, "R9", "lookup kept after disable", 32'(tlbSeen), 32'd1);
    chk(rspPaddr === mPaddr(32'h5000_0042), "R9", "lookup result after disable",
        rspPaddr, mPaddr(32'h5000_0042));
    release_rsp();
    access(32'h5000_0042, 2'd1, 1'b0, "R9 disable applies next");

    // Random mix
    for (int i = 0; i < 300; i++) begin
      if (($urandom % 6) == 0) cfgWrite(2'($urandom % 4), $urandom);
      if (($urandom % 5) == 0) cfgWrite(2'd0, 32'($urandom % 16));
      tlbLat = int'($urandom % 4);
      tlbAccDelay = int'($urandom % 3);
      access($urandom, 2'($urandom % 4), 1'($urandom % 2), "R3 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule